// File: doc/BRIEF.md
# RTC Alarm Match Unit

This block watches the running calendar time of a real-time clock and raises an alarm when that time equals a stored alarm setting. The timekeeping logic supplies the current seconds, minutes, hours, day-of-month and month as packed BCD bytes. It also supplies a one-cycle pulse once per second. The alarm fields and a control byte are loaded through a simple register write port.

A repeat mode selects which fields take part in the comparison. With every field compared, the alarm fires once a year. Fewer compared fields give monthly, daily, hourly or per-second alarms. When a comparison hits on a second pulse, a sticky flag is set. A read strobe on the flags register clears the flag. An enable bit decides whether the flag reaches the interrupt output.

Top module: `rtc_alarm_match`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into the register picked by `wr_addr`. The addresses are 0 seconds, 1 minutes, 2 hours, 3 day-of-month, 4 month and 5 control. In the control byte, bits 2:0 hold the repeat mode and bit 7 is the interrupt enable. Writes to addresses 6 and 7 change nothing.
- R2: After reset, `alarm_flag` and `irq` are 0, every alarm field is 00h, the repeat mode is 0 and the enable is 0.
- R3: In repeat mode 0, all five fields are compared as whole packed-BCD bytes. A tick on which every field is equal sets `alarm_flag` on the following clock edge.
- R4: Repeat mode 1 leaves the month out of the comparison.
- R5: Repeat mode 2 leaves out both month and day-of-month.
- R6: Repeat mode 3 compares only minutes and seconds.
- R7: Repeat mode 4 compares only seconds.
- R8: Repeat modes 5, 6 and 7 compare no field, so every tick sets the flag.
- R9: A comparison counts only in a cycle where `tick` is high. A matching time without a tick leaves the flag unchanged.
- R10: A `flag_rd` pulse clears `alarm_flag` on the next edge. If a tick match falls in the same cycle as the read, the flag stays set.
- R11: `irq` equals `alarm_flag` gated by the enable bit. The enable has no effect on the flag itself.
- R12: A tick compares the current time against the alarm values held before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | One-second pulse |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day-of-month, BCD |
| cur_mon | input | 8 | Current month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| flag_rd | input | 1 | Flags-register read strobe |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Interrupt, flag gated by enable |

## Verification
Directed cases put a time into each repeat mode in which exactly one field differs: the field just outside the mode's compared set, and then a field just inside it. This separates each mode's mask from its neighbours. Matching times held without a tick separate tick gating from a free-running compare. A read that coincides with a match separates set priority from clear priority. Random phases bias the current time toward the alarm so that hits are frequent. In those phases, writes, ticks, reads and enable changes interleave, which exposes write-before-compare ordering and enable gating against a bench model.

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int FW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [FW-1:0] cur_sec,
  input  logic [FW-1:0] cur_min,
  input  logic [FW-1:0] cur_hour,
  input  logic [FW-1:0] cur_date,
  input  logic [FW-1:0] cur_mon,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [FW-1:0] wr_data,
  input  logic          flag_rd,
  output logic          alarm_flag,
  output logic          irq
);
  localparam int NF   = 5;
  localparam int CTRL = NF;

  logic [FW-1:0] al_q  [NF];
  logic [FW-1:0] cur_v [NF];
  logic [2:0]    mode_q;
  logic          en_q;
  logic [NF-1:0] care, eq;
  logic          hit;

  assign cur_v[0] = cur_sec;
  assign cur_v[1] = cur_min;
  assign cur_v[2] = cur_hour;
  assign cur_v[3] = cur_date;
  assign cur_v[4] = cur_mon;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) al_q[i] <= '0;
      mode_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      for (int i = 0; i < NF; i++)
        if (wr_addr == AW'(i)) al_q[i] <= wr_data;
      if (wr_addr == AW'(CTRL)) begin
        mode_q <= wr_data[2:0];
        en_q   <= wr_data[FW-1];
      end
    end
  end

  for (genvar g = 0; g < NF; g++) begin : g_cmp
    assign eq[g] = (cur_v[g] == al_q[g]);
  end

  always_comb begin
    case (mode_q)
      3'd0:    care = 5'b11111;
      3'd1:    care = 5'b01111;
      3'd2:    care = 5'b00111;
      3'd3:    care = 5'b00011;
      3'd4:    care = 5'b00001;
      default: care = 5'b00000;
    endcase
  end

  assign hit = tick && (&(eq | ~care));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       alarm_flag <= 1'b0;
    else if (hit)     alarm_flag <= 1'b1;
    else if (flag_rd) alarm_flag <= 1'b0;
  end

  assign irq = alarm_flag & en_q;

  a_r3_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> alarm_flag);
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !hit) |=> !alarm_flag);
  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !flag_rd) |=> $stable(alarm_flag));
  a_r9_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(tick));
  a_r8_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode_q >= 3'd5) |=> alarm_flag);
  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> alarm_flag);
endmodule

// File: tb/test_rtc_alarm_match.sv
module test_rtc_alarm_match;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, flag_rd = 0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_date = 0, cur_mon = 0;
  logic [2:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic alarm_flag, irq;

  int total = 0, bad = 0;
  logic [7:0] m_al [5];
  logic [2:0] m_mode;
  logic m_en, m_flag;

  always #(CLK_P/2) clk = ~clk;

  rtc_alarm_match i_rtc_alarm_match (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_date(cur_date), .cur_mon(cur_mon),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .flag_rd(flag_rd),
    .alarm_flag(alarm_flag), .irq(irq));

  function automatic logic [4:0] care_of(input logic [2:0] m);
    case (m)
      3'd0: return 5'b11111;
      3'd1: return 5'b01111;
      3'd2: return 5'b00111;
      3'd3: return 5'b00011;
      3'd4: return 5'b00001;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic logic model_match();
    logic [7:0] c [5];
    logic [4:0] k;
    c[0] = cur_sec; c[1] = cur_min; c[2] = cur_hour; c[3] = cur_date; c[4] = cur_mon;
    k = care_of(m_mode);
    for (int i = 0; i < 5; i++) if (k[i] && c[i] != m_al[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [7:0] rbcd(input int maxv);
    int v;
    v = $urandom_range(maxv, 0);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic rd, input logic we,
                      input logic [2:0] a, input logic [7:0] d, input string req);
    tick = t; flag_rd = rd; wr_en = we; wr_addr = a; wr_data = d;
    if (t && model_match()) m_flag = 1'b1;
    else if (rd) m_flag = 1'b0;
    if (we) begin
      if (a < 3'd5) m_al[a] = d;
      else if (a == 3'd5) begin m_mode = d[2:0]; m_en = d[7]; end
    end
    @(posedge clk);
    @(negedge clk);
    tick = 0; flag_rd = 0; wr_en = 0;
    chk(req, alarm_flag, m_flag, "alarm_flag");
    chk(req, irq, m_flag & m_en, "irq");
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, dt, mo);
    cur_sec = s; cur_min = mi; cur_hour = h; cur_date = dt; cur_mon = mo;
  endtask

  task automatic load_alarm(input logic [2:0] mode, input logic en, input string req);
    step(0, 0, 1, 3'd0, 8'h30, req);
    step(0, 0, 1, 3'd1, 8'h45, req);
    step(0, 0, 1, 3'd2, 8'h12, req);
    step(0, 0, 1, 3'd3, 8'h25, req);
    step(0, 0, 1, 3'd4, 8'h06, req);
    step(0, 0, 1, 3'd5, {en, 4'b0, mode}, req);
    step(0, 1, 0, 3'd0, 8'h00, req);
  endtask

  // try: one field (idx) off by one against the alarm, tick once, expect per mode
  task automatic probe(input int idx, input string req);
    set_time(8'h30, 8'h45, 8'h12, 8'h25, 8'h06);
    case (idx)
      0: cur_sec = 8'h31;
      1: cur_min = 8'h46;
      2: cur_hour = 8'h13;
      3: cur_date = 8'h26;
      4: cur_mon = 8'h07;
      default: ;
    endcase
    step(1, 0, 0, 3'd0, 8'h00, req);
    step(0, 1, 0, 3'd0, 8'h00, req);
  endtask

  initial begin
    #(CLK_P * 20000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 5; i++) m_al[i] = 0;
    m_mode = 0; m_en = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state: all-zero alarm fields match an all-zero time in mode 0
    chk("R2", alarm_flag, 1'b0, "alarm_flag after reset");
    chk("R2", irq, 1'b0, "irq after reset");
    set_time(0, 0, 0, 0, 0);
    step(1, 0, 0, 3'd0, 8'h00, "R2");
    step(0, 1, 0, 3'd0, 8'h00, "R10");

    // R3 mode 0: exact match and each field mismatch
    load_alarm(3'd0, 1'b1, "R1");
    for (int f = -1; f < 5; f++) probe(f, "R3");
    // R4..R8 each mode against every field mismatch
    load_alarm(3'd1, 1'b1, "R1");
    for (int f = -1; f < 5; f++) probe(f, "R4");
    load_alarm(3'd2, 1'b1, "R1");
    for (int f = -1; f < 5; f++) probe(f, "R5");
    load_alarm(3'd3, 1'b1, "R1");
    for (int f = -1; f < 5; f++) probe(f, "R6");
    load_alarm(3'd4, 1'b1, "R1");
    for (int f = -1; f < 5; f++) probe(f, "R7");
    for (int m = 5; m < 8; m++) begin
      load_alarm(3'(m), 1'b1, "R1");
      probe(0, "R8");
    end

    // R9: match held without tick
    load_alarm(3'd0, 1'b1, "R1");
    set_time(8'h30, 8'h45, 8'h12, 8'h25, 8'h06);
    repeat (3) step(0, 0, 0, 3'd0, 8'h00, "R9");
    step(1, 0, 0, 3'd0, 8'h00, "R3");
    repeat (2) step(0, 0, 0, 3'd0, 8'h00, "R9");
    // R10: read together with match keeps flag; later read clears
    step(1, 1, 0, 3'd0, 8'h00, "R10");
    step(0, 1, 0, 3'd0, 8'h00, "R10");
    // R11: enable off keeps flag, hides irq
    step(0, 0, 1, 3'd5, 8'h00, "R11");
    step(1, 0, 0, 3'd0, 8'h00, "R11");
    step(0, 0, 1, 3'd5, 8'h80, "R11");
    step(0, 1, 0, 3'd0, 8'h00, "R11");
    // R1: writes to 6 and 7 ignored; alarm still matches
    step(0, 0, 1, 3'd6, 8'h99, "R1");
    step(0, 0, 1, 3'd7, 8'h05, "R1");
    step(1, 0, 0, 3'd0, 8'h00, "R1");
    step(0, 1, 0, 3'd0, 8'h00, "R1");
    // R12: write that breaks the match in the tick cycle; old value still used
    step(1, 0, 1, 3'd0, 8'h59, "R12");
    step(0, 1, 0, 3'd0, 8'h00, "R12");
    step(1, 0, 0, 3'd0, 8'h00, "R12");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic t, rd, we;
      logic [2:0] a;
      logic [7:0] d;
      string tag;
      cur_sec  = ($urandom_range(3, 0) != 0) ? m_al[0] : rbcd(59);
      cur_min  = ($urandom_range(3, 0) != 0) ? m_al[1] : rbcd(59);
      cur_hour = ($urandom_range(3, 0) != 0) ? m_al[2] : rbcd(23);
      cur_date = ($urandom_range(3, 0) != 0) ? m_al[3] : rbcd(31);
      cur_mon  = ($urandom_range(3, 0) != 0) ? m_al[4] : rbcd(12);
      t  = ($urandom_range(2, 0) == 0);
      rd = ($urandom_range(3, 0) == 0);
      we = ($urandom_range(9, 0) == 0);
      a  = 3'($urandom_range(7, 0));
      d  = (a == 3'd5) ? {1'($urandom_range(1, 0)), 4'b0, 3'($urandom_range(7, 0))} : rbcd(59);
      case (m_mode)
        3'd0: tag = "R3"; 3'd1: tag = "R4"; 3'd2: tag = "R5";
        3'd3: tag = "R6"; 3'd4: tag = "R7"; default: tag = "R8";
      endcase
      step(t, rd, we, a, d, tag);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule